// File: doc/BRIEF.md
# Configuration Access Address Decoder

This block sits between a configuration-access requester and a memory-mapped configuration window. Each request names a bus number, a device/function number and a register offset. The block first screens the request. Only function 0 is reachable on the root bus. Buses below the root are reachable only while the link reports up. The bus number may not exceed the last bus that the window covers, and nothing passes while the window is disabled. A request that passes is turned into a 64-bit local address: the window base plus the bus, device/function and offset fields packed at bit positions 20, 12 and 0.

A small register port holds a read-only capability word, a control word and the two halves of the window base. Software reads the capability bit before it enables the window. The block answers every request one cycle after acceptance, with a one-cycle response. That response carries a pass/reject flag and the computed address. It also carries the read data: the storage's data for an accepted access, all ones for a rejected one.

The controller has two states. `ST_IDLE` accepts a request (`req_ready` high). The transition `take` fires when `req_valid` is high, screens the request and registers the verdict. `ST_RESP` presents the response for exactly one cycle. The transition `retire` then returns unconditionally to `ST_IDLE`. Reset enters `ST_IDLE`.

Top module: `cfgdec_top`

## Requirements
- R1: After reset the control word reads enable 0 with size field 12, both base halves read 0, the capability word reads 1, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted request yields `rsp_addr` = base + (bus << 20) + (devfn << 12) + offset, computed over the full 64 bits with carry from the low half into the high half.
- R3: A request on the root bus (parameter, default 0) with a non-zero device/function value is rejected, whatever the link state.
- R4: A request on any bus other than the root bus is rejected while `link_up` is low; the root bus is not gated by `link_up`.
- R5: A request whose bus number exceeds the control size field (control bits 20:16, the last valid bus) is rejected; a bus equal to it passes.
- R6: While the control enable bit (control bit 0) is clear, every request is rejected.
- R7: A rejected request gives `rsp_ok` low, `rsp_addr` zero and `rsp_rdata` all ones; after an accepted one `rsp_rdata` follows `mem_rdata`.
- R8: A request taken in `ST_IDLE` produces `rsp_valid` high in the next cycle only, with `req_ready` low during that cycle; a request presented while `req_ready` is low is ignored.
- R9: Register select 0 is the capability word (bit 0, writes ignored), 1 the control word (enable bit 0, size bits 20:16, other bits read 0), 2 the low and 3 the high base word; `reg_rdata` shows the selected word combinationally, and a write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 capability, 1 control, 2 base low, 3 base high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| link_up | input | 1 | Link reports up |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_off | input | 12 | Register offset in the function's space |
| mem_rdata | input | 32 | Read data from configuration storage |
| rsp_valid | output | 1 | Response cycle |
| rsp_ok | output | 1 | Request passed screening |
| rsp_addr | output | 64 | Local window address (zero when rejected) |
| rsp_rdata | output | 32 | Read data, all ones when rejected |

## Verification
The bench goes after the boundary cases of the screen. The first is a bus number equal to the size field against one above it. A design with an off-by-one comparison would pass a bus one past the window or drop the last one. The bench also runs a non-zero function on the root bus with the link down and up. This catches a design that applies the link gate to the root bus, or that misses the function-0 rule. A base chosen so that the field sum carries into the high word catches a 32-bit adder. A request held high across the response cycle catches a controller that takes a second request before retiring the first. Writes to the capability word and to unused control bits show up as stray read-back bits in a design that stores them.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    typedef enum logic [1:0] {
        SEL_CAP     = 2'd0,
        SEL_CTRL    = 2'd1,
        SEL_BASE_LO = 2'd2,
        SEL_BASE_HI = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int SIZE_LSB    = 16;
    localparam int SIZE_W      = 5;

    typedef struct packed {
        logic disabled;
        logic beyond_last;
        logic fn_on_root;
        logic link_down;
    } reject_t;

endpackage

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
    import cfgdec_pkg::*;
#(
    parameter int               REG_W       = 32,
    parameter logic [SIZE_W-1:0] SIZE_RST   = 5'd12,
    parameter bit               CAP_PRESENT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  reg_sel_e             sel,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic                 en,
    output logic [SIZE_W-1:0]    size,
    output logic [2*REG_W-1:0]   base
);

    logic [REG_W-1:0] half_q [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            size <= SIZE_RST;
        end else if (we && sel == SEL_CTRL) begin
            en   <= wdata[CTRL_EN_BIT];
            size <= wdata[SIZE_LSB +: SIZE_W];
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (we && sel == reg_sel_e'(2'(SEL_BASE_LO) + 2'(h))) begin
                half_q[h] <= wdata;
            end
        end
    end

    assign base = {half_q[1], half_q[0]};

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CAP:     rdata[0] = CAP_PRESENT;
            SEL_CTRL: begin
                rdata[CTRL_EN_BIT]          = en;
                rdata[SIZE_LSB +: SIZE_W]   = size;
            end
            SEL_BASE_LO: rdata = half_q[0];
            SEL_BASE_HI: rdata = half_q[1];
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgdec_screen.sv
module cfgdec_screen
    import cfgdec_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int DEVFN_W  = 8,
    parameter int OFF_W    = 12,
    parameter int ADDR_W   = 64,
    parameter int ROOT_BUS = 0
) (
    input  logic                en,
    input  logic [SIZE_W-1:0]   size,
    input  logic [ADDR_W-1:0]   base,
    input  logic                link_up,
    input  logic [BUS_W-1:0]    bus,
    input  logic [DEVFN_W-1:0]  devfn,
    input  logic [OFF_W-1:0]    off,
    output reject_t             why,
    output logic                ok,
    output logic [ADDR_W-1:0]   addr
);

    localparam int WIN_W = BUS_W + DEVFN_W + OFF_W;
    localparam int CMP_W = (BUS_W > SIZE_W) ? BUS_W : SIZE_W;
    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic [WIN_W-1:0] win;

    always_comb begin
        why.disabled    = !en;
        why.beyond_last = CMP_W'(bus) > CMP_W'(size);
        why.fn_on_root  = (bus == ROOT) && (devfn != '0);
        why.link_down   = (bus != ROOT) && !link_up;
        ok              = !(|why);
        // bus lands at bit OFF_W+DEVFN_W, devfn at bit OFF_W
        win             = {bus, devfn, off};
        addr            = base + ADDR_W'(win);
    end

endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter int               REG_W       = 32,
    parameter int               BUS_W       = 8,
    parameter int               DEVFN_W     = 8,
    parameter int               OFF_W       = 12,
    parameter int               ROOT_BUS    = 0,
    parameter logic [SIZE_W-1:0] SIZE_RST   = 5'd12,
    parameter bit               CAP_PRESENT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               link_up,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [REG_W-1:0]   mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [2*REG_W-1:0] rsp_addr,
    output logic [REG_W-1:0]   rsp_rdata
);

    localparam int ADDR_W = 2 * REG_W;

    fsm_e                state_q, state_d;
    logic                ctl_en;
    logic [SIZE_W-1:0]   ctl_size;
    logic [ADDR_W-1:0]   win_base;
    reject_t             scr_why;
    logic                scr_ok;
    logic [ADDR_W-1:0]   scr_addr;
    logic                take;
    logic                ok_q;
    logic [ADDR_W-1:0]   addr_q;

    cfgdec_regs #(
        .REG_W       (REG_W),
        .SIZE_RST    (SIZE_RST),
        .CAP_PRESENT (CAP_PRESENT)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (reg_sel_e'(reg_sel)),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en    (ctl_en),
        .size  (ctl_size),
        .base  (win_base)
    );

    cfgdec_screen #(
        .BUS_W    (BUS_W),
        .DEVFN_W  (DEVFN_W),
        .OFF_W    (OFF_W),
        .ADDR_W   (ADDR_W),
        .ROOT_BUS (ROOT_BUS)
    ) u_screen (
        .en      (ctl_en),
        .size    (ctl_size),
        .base    (win_base),
        .link_up (link_up),
        .bus     (req_bus),
        .devfn   (req_devfn),
        .off     (req_off),
        .why     (scr_why),
        .ok      (scr_ok),
        .addr    (scr_addr)
    );

    // next-state: take in IDLE, retire from RESP
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take    = 1'b1;
                    state_d = ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // verdict capture; the reject cause is folded into ok
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q   <= 1'b0;
            addr_q <= '0;
        end else if (take) begin
            ok_q   <= scr_ok;
            addr_q <= scr_ok ? scr_addr : '0;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_ok    = ok_q;
        rsp_addr  = addr_q;
        rsp_rdata = ok_q ? mem_rdata : '1;
    end

endmodule

// File: rtl/cfgdec_checks.sv
module cfgdec_checks
    import cfgdec_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int BUS_W    = 8,
    parameter int DEVFN_W  = 8,
    parameter int ROOT_BUS = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [BUS_W-1:0]   req_bus,
    input logic [DEVFN_W-1:0] req_devfn,
    input logic               link_up,
    input logic               ctl_en,
    input logic [SIZE_W-1:0]  ctl_size,
    input logic               rsp_valid,
    input logic               rsp_ok,
    input logic [2*REG_W-1:0] rsp_addr,
    input logic [REG_W-1:0]   rsp_rdata
);

    localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

    logic taken;
    assign taken = req_valid && req_ready;

    a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> rsp_valid);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !ctl_en) |=> !rsp_ok);

    a_r3_root_fn: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_bus == ROOT && req_devfn != '0) |=> !rsp_ok);

    a_r4_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_bus != ROOT && !link_up) |=> !rsp_ok);

    a_r5_past_last: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && (32'(req_bus) > 32'(ctl_size))) |=> !rsp_ok);

    a_r7_reject_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_rdata == '1 && rsp_addr == '0));

endmodule

bind cfgdec_top cfgdec_checks #(
    .REG_W    (REG_W),
    .BUS_W    (BUS_W),
    .DEVFN_W  (DEVFN_W),
    .ROOT_BUS (ROOT_BUS)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bus   (req_bus),
    .req_devfn (req_devfn),
    .link_up   (link_up),
    .ctl_en    (ctl_en),
    .ctl_size  (ctl_size),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_addr  (rsp_addr),
    .rsp_rdata (rsp_rdata)
);

// File: tb/test_cfgdec_top.sv
module test_cfgdec_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROOT       = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_rdata;

    int    vecs = 0;
    int    miscmp = 0;
    string tag = "R1";

    // behavioural reference state
    logic        m_live = 1'b0;
    logic        m_en;
    logic [4:0]  m_size;
    logic [63:0] m_base;
    logic        m_busy;
    logic        m_ok;
    logic [63:0] m_addr;

    cfgdec_top i_cfgdec_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_off(req_off), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
        .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        m_live = 1'b1;
        if (!rst_n) begin
            m_en = 1'b0; m_size = 5'd12; m_base = '0;
            m_busy = 1'b0; m_ok = 1'b0; m_addr = '0;
        end else begin
            if (m_busy) begin
                m_busy = 1'b0;
            end else if (req_valid) begin
                m_busy = 1'b1;
                m_ok = m_en && (int'(req_bus) <= int'(m_size))
                       && !(int'(req_bus) == ROOT && req_devfn != 0)
                       && !(int'(req_bus) != ROOT && !link_up);
                m_addr = m_ok ? m_base + 64'(req_bus) * 64'h10_0000
                                + 64'(req_devfn) * 64'h1000 + 64'(req_off) : 64'd0;
            end
            if (reg_we) begin
                case (reg_sel)
                    2'd1: begin m_en = reg_wdata[0]; m_size = reg_wdata[20:16]; end
                    2'd2: m_base[31:0]  = reg_wdata;
                    2'd3: m_base[63:32] = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_reg(input logic [1:0] s);
        case (s)
            2'd0: return 32'h1;
            2'd1: return {11'd0, m_size, 15'd0, m_en};
            2'd2: return m_base[31:0];
            default: return m_base[63:32];
        endcase
    endfunction

    task automatic cmp(input string what, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live) begin
            cmp("rsp_valid", "R8", 64'(rsp_valid), 64'(m_busy));
            cmp("req_ready", "R8", 64'(req_ready), 64'(!m_busy));
            cmp("reg_rdata", (tag == "R1") ? "R1" : "R9", 64'(reg_rdata), 64'(exp_reg(reg_sel)));
            cmp("rsp_rdata", "R7", 64'(rsp_rdata), 64'(m_ok ? mem_rdata : 32'hFFFF_FFFF));
            if (m_busy) begin
                cmp("rsp_ok", tag, 64'(rsp_ok), 64'(m_ok));
                cmp("rsp_addr", tag, rsp_addr, m_addr);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rq(input logic [7:0] b, input logic [7:0] f, input logic [11:0] o,
                      input logic [31:0] md, input int hold);
        req_valid = 1'b1; req_bus = b; req_devfn = f; req_off = o; mem_rdata = md;
        repeat (hold) step();
        req_valid = 1'b0;
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscmp++;
        $display("FAIL R8 watchdog: actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miscmp);
        $finish;
    end

    initial begin
        // R1: reset values seen on every select
        tag = "R1";
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            step();
        end
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            step();
        end

        // R9: capability ignores writes; unused control bits read 0
        tag = "R9";
        wr(2'd0, 32'h0);
        reg_sel = 2'd0; step();
        wr(2'd1, 32'hFFE0_FFFE);
        reg_sel = 2'd1; step();

        // R6: disabled window rejects even a legal root access (R7 fill)
        tag = "R6";
        link_up = 1'b1;
        rq(8'd0, 8'd0, 12'h004, 32'h1234_5678, 1);
        rq(8'd1, 8'd0, 12'h000, 32'h1234_5678, 1);

        // R2: enable, base chosen to carry into the high word
        tag = "R2";
        wr(2'd1, 32'h000C_0001);
        wr(2'd2, 32'hFFFF_F000);
        wr(2'd3, 32'h0000_0001);
        link_up = 1'b0;
        rq(8'd0, 8'd0, 12'h010, 32'hCAFE_0001, 1);

        // R3: non-zero function on root bus, link both ways
        tag = "R3";
        rq(8'd0, 8'd3, 12'h000, 32'hCAFE_0002, 1);
        link_up = 1'b1;
        rq(8'd0, 8'd1, 12'h000, 32'hCAFE_0003, 1);

        // R4: downstream bus gated by link
        tag = "R4";
        link_up = 1'b0;
        rq(8'd1, 8'd0, 12'h000, 32'hCAFE_0004, 1);
        link_up = 1'b1;
        tag = "R2";
        rq(8'd1, 8'h08, 12'hFFC, 32'hCAFE_0005, 1);

        // R5: last bus passes, one beyond fails, widen and retry
        tag = "R5";
        rq(8'd12, 8'h1F, 12'h100, 32'hCAFE_0006, 1);
        rq(8'd13, 8'h00, 12'h100, 32'hCAFE_0007, 1);
        wr(2'd1, 32'h001F_0001);
        rq(8'd13, 8'h00, 12'h100, 32'hCAFE_0008, 1);
        rq(8'd32, 8'h00, 12'h000, 32'hCAFE_0009, 1);

        // R8: request held across the response cycle is taken twice, not thrice
        tag = "R8";
        rq(8'd2, 8'd5, 12'h040, 32'hCAFE_000A, 3);

        // R7: mixed pass/reject stream with varying read data
        tag = "R7";
        for (int i = 0; i < 150; i++) begin
            link_up = 1'($urandom_range(0, 3) != 0);
            if (i % 37 == 0) wr(2'd1, {11'd0, 5'($urandom_range(0, 31)), 15'd0, 1'b1});
            rq(8'($urandom_range(0, 40)), ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'd0,
               12'($urandom), $urandom, 1);
        end

        // R6: disable again
        tag = "R6";
        wr(2'd1, 32'h001F_0000);
        rq(8'd0, 8'd0, 12'h000, 32'h5555_AAAA, 1);
        step();

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miscmp);
        $finish;
    end

endmodule